// File: doc/BRIEF.md
# Dual-Processor Control Latch with Timed Map Switch

This block is a control point shared by two processors. A single write port sets or clears one of eight control outputs, each chosen by an address carried in the write data. Each output has a fixed role for one of the two CPUs: an inter-processor interrupt request, an NMI-reset control, a requested memory-map select, or a fast-interrupt request.

Each CPU also has a map register. A write to it loads a short countdown. When the countdown expires, that CPU's active memory map takes the value of its requested map-select bit. Software can therefore arm a map change and then run a few more instructions before the change lands. A vector-fetch input per CPU returns that CPU to the system map (value 0) at once and cancels any pending countdown. A registered status word gives both active maps and the identity of the CPU that is reading.

Top module: `dual_cpu_ctl`

## Requirements
- R1: A cycle with `lat_we` high stores `lat_wdata[3]` into output number `lat_wdata[2:0]` at that clock edge. The other seven outputs keep their values.
- R2: Output numbers map to roles as 2*role+cpu. Roles: 0 = inter-processor interrupt (`ipi_req`), 1 = NMI-reset (`nmi_rst`), 2 = requested map (`map_req`), 3 = fast interrupt (`fiq_req`). Bit [c] of each output bus belongs to CPU c.
- R3: A cycle with `map_we[c]` high loads `map_wdata[3:0]` as delay d. `act_map[c]` holds its value through the next d edges and takes `map_req[c]` at edge d+1 after the write edge.
- R4: A delay of 0 applies the map switch at the first edge after the write edge.
- R5: A map write to a CPU whose countdown is still running restarts that countdown from the new value. The old countdown has no further effect.
- R6: The requested map is sampled at the expiry edge. A change of `map_req[c]` written at or after that edge does not change `act_map[c]`.
- R7: At every edge `map_stat` is loaded with {`act_map[1]`, `act_map[0]`, `rd_cpu`}, using the values present before that edge.
- R8: A cycle with `vec_fetch[c]` high sets `act_map[c]` to 0 at that edge and cancels any running countdown of CPU c. A vector fetch takes priority over a map write in the same cycle.
- R9: While `rst_n` is low, all eight latch outputs, both active maps and `map_stat` are 0, and pending countdowns are cancelled.
- R10: A map write or vector fetch for one CPU leaves the other CPU's active map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_we | input | 1 | Control latch write strobe |
| lat_wdata | input | 4 | Bit 3 is the value, bits 2..0 select the output |
| map_we | input | 2 | Map register write strobe, one per CPU |
| map_wdata | input | 4 | Countdown value for a map write |
| vec_fetch | input | 2 | Vector fetch in progress, one per CPU |
| rd_cpu | input | 1 | Number of the CPU reading the status |
| ipi_req | output | 2 | Inter-processor interrupt requests |
| nmi_rst | output | 2 | NMI-reset controls |
| map_req | output | 2 | Requested map selects |
| fiq_req | output | 2 | Fast-interrupt requests |
| act_map | output | 2 | Active map per CPU (0 = system map) |
| map_stat | output | 3 | Status: {act_map[1], act_map[0], rd_cpu} |

## Verification
The bench times each map switch to the exact edge. An off-by-one countdown would show the new map one edge early or late, and a zero delay that is handled wrongly would either stall or wrap to a long wait. It rewrites a map register in the middle of a countdown, and changes the requested bit on the same edge the countdown expires. A design that kept the first countdown would switch too early, and one that sampled the request late would take the new value. It also issues a vector fetch during a countdown and a reset during a countdown. Both must cancel the countdown: a design that left it armed would later move the CPU off the system map with no write.

// File: rtl/dual_cpu_ctl_pkg.sv
package dual_cpu_ctl_pkg;

  localparam int NCPU   = 2;
  localparam int NROLE  = 4;
  localparam int NLAT   = NCPU * NROLE;
  localparam int SEL_W  = $clog2(NLAT);
  localparam int DLY_W  = 4;

  typedef enum logic [1:0] {
    ROLE_IPI = 2'd0,
    ROLE_NMI = 2'd1,
    ROLE_MAP = 2'd2,
    ROLE_FIQ = 2'd3
  } ctl_role_e;

  // position of a role bit for a CPU inside the latch word
  function automatic int lat_pos(input ctl_role_e role, input int cpu);
    return int'(role) * NCPU + cpu;
  endfunction

  // countdown step, saturating at zero
  function automatic logic [DLY_W-1:0] count_step(input logic [DLY_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

endpackage

// File: rtl/ctl_latch.sv
module ctl_latch #(
  parameter int N     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W:0]   wdata,
  output logic [N-1:0]     q
);

  logic [SEL_W-1:0] sel;
  logic             val;
  logic [N-1:0]     hit;

  assign sel = wdata[SEL_W-1:0];
  assign val = wdata[SEL_W];

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hit[i] = we && (sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (hit[i]) q[i] <= val;
    end
  end

  // R1: a write touches at most one output
  assert_single_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ($countones(q ^ $past(q)) <= 1));

  // R1: without a write nothing moves
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && $past(rst_n)) |=> $stable(q));

  // R1: strobes are exclusive
  assert_hit_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/map_timer.sv
module map_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             req,
  input  logic             fetch,
  output logic             act,
  output logic             busy,
  output logic             expire
);

  logic [DLY_W-1:0] cnt;

  assign expire = busy && (cnt == '0) && !fetch && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      act  <= 1'b0;
    end else if (fetch) begin
      busy <= 1'b0;
      act  <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) begin
        act  <= req;
        busy <= 1'b0;
      end else begin
        cnt <= dual_cpu_ctl_pkg::count_step(cnt);
      end
    end
  end

  // R8: fetch forces the system map and cancels the countdown
  assert_fetch_sys_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> (!act && !busy));

  // R3: on expiry the active map follows the request seen at that edge
  assert_expire_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (act == $past(req)));

  // R5: a load without fetch (re)arms the countdown
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !fetch) |=> busy);

  // R6: with no countdown ending and no fetch, the active map is steady
  assert_act_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && !fetch && $past(rst_n)) |=> $stable(act));

  // R9: leaving reset on the system map
  assert_reset_sys_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (!act && !busy));

endmodule

// File: rtl/dual_cpu_ctl.sv
module dual_cpu_ctl
  import dual_cpu_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_we,
  input  logic [3:0]       lat_wdata,
  input  logic [1:0]       map_we,
  input  logic [3:0]       map_wdata,
  input  logic [1:0]       vec_fetch,
  input  logic             rd_cpu,
  output logic [1:0]       ipi_req,
  output logic [1:0]       nmi_rst,
  output logic [1:0]       map_req,
  output logic [1:0]       fiq_req,
  output logic [1:0]       act_map,
  output logic [2:0]       map_stat
);

  logic [NLAT-1:0] lat_q;
  logic [NCPU-1:0] tmr_busy;
  logic [NCPU-1:0] tmr_expire;

  ctl_latch #(.N(NLAT), .SEL_W(SEL_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lat_we),
    .wdata (lat_wdata[SEL_W:0]),
    .q     (lat_q)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign ipi_req[c] = lat_q[lat_pos(ROLE_IPI, c)];
    assign nmi_rst[c] = lat_q[lat_pos(ROLE_NMI, c)];
    assign map_req[c] = lat_q[lat_pos(ROLE_MAP, c)];
    assign fiq_req[c] = lat_q[lat_pos(ROLE_FIQ, c)];

    map_timer #(.DLY_W(DLY_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (map_we[c]),
      .load_val (map_wdata[DLY_W-1:0]),
      .req      (map_req[c]),
      .fetch    (vec_fetch[c]),
      .act      (act_map[c]),
      .busy     (tmr_busy[c]),
      .expire   (tmr_expire[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) map_stat <= '0;
    else        map_stat <= {act_map[1], act_map[0], rd_cpu};
  end

  // R10: quiet CPU 1 keeps its map while CPU 0 is busy
  assert_cpu_isolate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_we[1] && !vec_fetch[1] && !tmr_busy[1] && $past(rst_n))
      |=> $stable(act_map[1]));

  // R7: reader identity bit follows the reader
  assert_stat_reader_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (map_stat[0] == $past(rd_cpu)));

  // R9: nothing pending right after reset
  assert_reset_idle_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (tmr_busy == '0 && lat_q == '0));

endmodule

// File: tb/dual_cpu_ctl_bench.sv
module dual_cpu_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lat_we = 1'b0;
  logic [3:0] lat_wdata = '0;
  logic [1:0] map_we = '0;
  logic [3:0] map_wdata = '0;
  logic [1:0] vec_fetch = '0;
  logic       rd_cpu = 1'b0;
  logic [1:0] ipi_req, nmi_rst, map_req, fiq_req, act_map;
  logic [2:0] map_stat;

  always #2 clk = ~clk;

  dual_cpu_ctl u_dual_cpu_ctl (
    .clk(clk), .rst_n(rst_n), .lat_we(lat_we), .lat_wdata(lat_wdata),
    .map_we(map_we), .map_wdata(map_wdata), .vec_fetch(vec_fetch),
    .rd_cpu(rd_cpu), .ipi_req(ipi_req), .nmi_rst(nmi_rst),
    .map_req(map_req), .fiq_req(fiq_req), .act_map(act_map),
    .map_stat(map_stat)
  );

  typedef struct {
    string      tag;
    int         kind;   // 0: {act, latch}, 1: status
    logic [9:0] val;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  logic [7:0] m_lat = '0;
  logic [1:0] m_act = '0;

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string tag);
    exp_t e;
    e.tag = tag; e.kind = 0; e.val = {m_act, m_lat};
    q.push_back(e);
    -> chk_ev;
  endtask

  task automatic expect_stat(string tag);
    exp_t e;
    e.tag = tag; e.kind = 1; e.val = {7'd0, m_act[1], m_act[0], rd_cpu};
    q.push_back(e);
    -> chk_ev;
  endtask

  // monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        logic [9:0] got;
        e = q.pop_front();
        if (e.kind == 0) got = {act_map, fiq_req, map_req, nmi_rst, ipi_req};
        else             got = {7'd0, map_stat};
        n_chk++;
        if (got !== e.val) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", e.tag, got, e.val);
        end
      end
    end
  end

  task automatic lat_wr(int sel, bit v);
    lat_we = 1'b1; lat_wdata = {v, 3'(sel)};
    step();
    lat_we = 1'b0;
    m_lat[sel] = v;
  endtask

  task automatic map_wr(int cpu, int d);
    map_we[cpu] = 1'b1; map_wdata = 4'(d);
    step();
    map_we = '0;
  endtask

  initial begin
    step(3);
    expect_out("R9 outputs in reset");
    rst_n = 1'b1;
    step();
    expect_out("R9 after reset");
    expect_stat("R7 status cpu0");
    rd_cpu = 1'b1; step();
    expect_stat("R7 status cpu1 bit");
    rd_cpu = 1'b0;

    // R1 R2: walk all eight outputs
    for (int i = 0; i < 8; i++) begin
      lat_wr(i, 1'b1);
      expect_out("R2 set output role");
    end
    lat_wr(3, 1'b0);
    expect_out("R1 clear one output only");
    lat_wr(1, 1'b0);
    lat_wr(1, 1'b1);
    expect_out("R1 rewrite one output");

    // R3: delay 3 on CPU 0, request is 1
    map_wr(0, 3);
    expect_out("R3 no change at write");
    step(3);
    expect_out("R3 still old after d edges");
    step(); m_act[0] = 1'b1;
    expect_out("R3 switched at d+1");
    expect_out("R10 cpu1 untouched");

    // R4: delay 0 on CPU 1
    map_wr(1, 0);
    expect_out("R4 not yet at write edge");
    step(); m_act[1] = 1'b1;
    expect_out("R4 switched next edge");
    step();
    expect_stat("R7 both maps cpu0 reader");
    rd_cpu = 1'b1; step();
    expect_stat("R7 both maps cpu1 reader");
    rd_cpu = 1'b0;

    // R5: restart countdown, request 0 for CPU 0
    lat_wr(4, 1'b0);
    map_wr(0, 6);
    step(2);
    map_wr(0, 2);
    step(2);
    expect_out("R5 old countdown ignored");
    step(); m_act[0] = 1'b0;
    expect_out("R5 restarted countdown expired");

    // R6: request changes on the expiry edge
    lat_wr(5, 1'b0);
    map_wr(1, 1);
    step();
    lat_wr(5, 1'b1);   // this edge is the expiry edge
    m_act[1] = 1'b0;
    expect_out("R6 sampled old request");
    step(3);
    expect_out("R6 late request ignored");

    // R8: vector fetch cancels a countdown
    map_wr(1, 0);
    step(); m_act[1] = 1'b1;
    expect_out("R8 setup map 1");
    map_wr(1, 5);
    step();
    vec_fetch = 2'b10;
    step();
    vec_fetch = '0;
    m_act[1] = 1'b0;
    expect_out("R8 forced to system map");
    step(8);
    expect_out("R8 countdown cancelled");
    // fetch wins over same-cycle map write
    map_we = 2'b10; map_wdata = 4'd0; vec_fetch = 2'b10;
    step();
    map_we = '0; vec_fetch = '0;
    step(3);
    expect_out("R8 fetch beats map write");

    // R9: reset cancels countdown
    lat_wr(4, 1'b1);
    map_wr(0, 4);
    rst_n = 1'b0;
    step(2);
    m_lat = '0; m_act = '0;
    expect_out("R9 cleared in reset");
    expect_stat("R9 status cleared");
    rst_n = 1'b1;
    step(8);
    expect_out("R9 countdown cancelled");

    step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule